// File: doc/BRIEF.md
# Shared Timer Clock Prescaler

This block gives two timer/counters their count enables from one divider chain that runs freely. Each timer has its own 3-bit clock select. The select picks one of these sources:

- off;
- every system cycle;
- one of four divided rates (1/8, 1/64, 1/256 and 1/1024);
- an external pin, counted on its falling or its rising edge.

The block does not produce derived clocks. It produces one-cycle enable strobes, registered in the system clock domain, that the timers use to qualify their counting.

The divider is shared, and no select ever stops it or restarts it. A timer that switches onto a divided rate therefore sees its first strobe at a time set by the phase of the divider. Firmware can pulse the synchronous divider clear to align a timer with program flow. That clear also moves the phase of the other timer whenever that timer uses a divided rate.

There is no data path, so no port uses a valid/ready handshake. Every port is a plain level or a plain pulse, sampled on the rising clock edge.

Top module: `tps_shared_prescaler`

## Requirements
- R1: A select value of 0 keeps that timer's strobe low.
- R2: A select value of 1 drives that timer's strobe high in every cycle. The strobe register follows the select one edge later.
- R3: Select values 2, 3, 4 and 5 give divisors 8, 64, 256 and 1024. The strobe is high for exactly one cycle in each period of N cycles.
- R4: Changing a select never clears or pauses the divider. After a switch from 0 to a divided rate of divisor N, the first strobe is seen between 1 and N+1 cycles later, on the divider's existing phase.
- R5: The prescaler clear, when sampled high at a rising edge, zeroes the divider and suppresses any divided strobe from that edge. With divisor N selected, the first strobe becomes visible exactly N rising edges after the clearing edge.
- R6: A clear issued for one timer also realigns the divided strobes of the other timer.
- R7: The two timers may select different divided rates at the same time, and each receives its own rate.
- R8: Select 7 counts rising edges of the timer's pin and select 6 counts falling edges. The pin passes through a two-flop synchronizer and an edge register. Each qualifying edge gives exactly one strobe, visible 3 rising edges after the pin changes.
- R9: While the active-low reset is asserted, both strobes are low and the divider is zero. The first divided strobe after the reset is released follows the timing of R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| presc_clr | input | 1 | Synchronous clear of the shared divider |
| sel0 | input | 3 | Clock select, timer 0 |
| sel1 | input | 3 | Clock select, timer 1 |
| ext_pin0 | input | 1 | External count pin, timer 0 (asynchronous) |
| ext_pin1 | input | 1 | External count pin, timer 1 (asynchronous) |
| tick0 | output | 1 | Count-enable strobe, timer 0 |
| tick1 | output | 1 | Count-enable strobe, timer 1 |

## Verification
The bench measures the position of the first strobe after a clear, and the spacing between strobes, for every select value. A design whose tap mapping or wrap detection is off by one would place these strobes at the wrong positions.

It switches a select off and back on in the middle of a period. A design that restarted the divider whenever a select changed would then lose its alignment to multiples of the divisor.

It clears the divider while the other timer runs at 1/1024, and checks that the other timer's next strobe lands a full period after the clear rather than on its old phase. It also checks the three-edge latency of the pin path and the polarity of each edge. A mistake in the number of synchronizer stages, or in which edge is counted, shows up there directly.

// File: rtl/tps_pkg.sv
package tps_pkg;
  typedef enum logic [2:0] {
    CS_OFF      = 3'd0,
    CS_DIRECT   = 3'd1,
    CS_DIV8     = 3'd2,
    CS_DIV64    = 3'd3,
    CS_DIV256   = 3'd4,
    CS_DIV1024  = 3'd5,
    CS_PIN_FALL = 3'd6,
    CS_PIN_RISE = 3'd7
  } clk_sel_e;

  localparam int NUM_TAPS = 4;

  // log2 of the divisor for each divided tap, ascending
  function automatic int tap_shift(input int idx);
    case (idx)
      0:       return 3;
      1:       return 6;
      2:       return 8;
      default: return 10;
    endcase
  endfunction
endpackage

// File: rtl/tps_divider.sv
module tps_divider #(
  parameter int DIV_W = 10
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  output logic [tps_pkg::NUM_TAPS-1:0] tap_hit
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else          cnt_q <= cnt_q + 1'b1;
  end

  // A tap is flagged in the last cycle before its low bits wrap to zero
  for (genvar i = 0; i < tps_pkg::NUM_TAPS; i++) begin : g_tap
    localparam int SH = tps_pkg::tap_shift(i);
    assign tap_hit[i] = !clr && (&cnt_q[SH-1:0]);
  end
endmodule

// File: rtl/tps_pin_edge.sv
module tps_pin_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~prev_q;
  assign fall = ~sync_q[STAGES-1] & prev_q;
endmodule

// File: rtl/tps_tick_sel.sv
module tps_tick_sel (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [2:0]                   sel,
  input  logic [tps_pkg::NUM_TAPS-1:0] tap_hit,
  input  logic                         pin_rise,
  input  logic                         pin_fall,
  output logic                         tick
);
  import tps_pkg::*;
  logic tick_d;

  always_comb begin
    case (clk_sel_e'(sel))
      CS_OFF:      tick_d = 1'b0;
      CS_DIRECT:   tick_d = 1'b1;
      CS_DIV8:     tick_d = tap_hit[0];
      CS_DIV64:    tick_d = tap_hit[1];
      CS_DIV256:   tick_d = tap_hit[2];
      CS_DIV1024:  tick_d = tap_hit[3];
      CS_PIN_FALL: tick_d = pin_fall;
      CS_PIN_RISE: tick_d = pin_rise;
      default:     tick_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick <= 1'b0;
    else        tick <= tick_d;
  end
endmodule

// File: rtl/tps_shared_prescaler.sv
module tps_shared_prescaler #(
  parameter int DIV_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       presc_clr,
  input  logic [2:0] sel0,
  input  logic [2:0] sel1,
  input  logic       ext_pin0,
  input  logic       ext_pin1,
  output logic       tick0,
  output logic       tick1
);
  localparam int N_TMR = 2;

  logic [tps_pkg::NUM_TAPS-1:0] tap_hit;
  logic [N_TMR-1:0][2:0]        sel_a;
  logic [N_TMR-1:0]             pin_a, rise_a, fall_a, tick_a;

  assign sel_a = {sel1, sel0};
  assign pin_a = {ext_pin1, ext_pin0};

  tps_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .clr(presc_clr), .tap_hit(tap_hit)
  );

  for (genvar t = 0; t < N_TMR; t++) begin : g_tmr
    tps_pin_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .pin(pin_a[t]),
      .rise(rise_a[t]), .fall(fall_a[t])
    );
    tps_tick_sel u_sel (
      .clk(clk), .rst_n(rst_n), .sel(sel_a[t]), .tap_hit(tap_hit),
      .pin_rise(rise_a[t]), .pin_fall(fall_a[t]), .tick(tick_a[t])
    );
  end

  assign tick0 = tick_a[0];
  assign tick1 = tick_a[1];
endmodule

// File: rtl/tps_checker.sv
module tps_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       presc_clr,
  input logic [2:0] sel0,
  input logic [2:0] sel1,
  input logic       tick0,
  input logic       tick1
);
  AST_OFF_SILENT_T0: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sel0) == 3'd0) |-> !tick0); // R1
  AST_OFF_SILENT_T1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sel1) == 3'd0) |-> !tick1); // R1
  AST_DIRECT_EVERY_T0: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sel0) == 3'd1 && $past(rst_n)) |-> tick0); // R2
  AST_DIV_SINGLE_T0: assert property (@(posedge clk) disable iff (!rst_n)
    (tick0 && $past(sel0) >= 3'd2 && $past(sel0) <= 3'd5
     && sel0 >= 3'd2 && sel0 <= 3'd5) |=> !tick0); // R3
  AST_DIV_SINGLE_T1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick1 && $past(sel1) >= 3'd2 && $past(sel1) <= 3'd5
     && sel1 >= 3'd2 && sel1 <= 3'd5) |=> !tick1); // R3
  AST_CLR_QUIET_T0: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(presc_clr) && $past(sel0) >= 3'd2 && $past(sel0) <= 3'd5) |-> !tick0); // R5
  AST_CLR_QUIET_T1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(presc_clr) && $past(sel1) >= 3'd2 && $past(sel1) <= 3'd5) |-> !tick1); // R6
  AST_PIN_SINGLE_T0: assert property (@(posedge clk) disable iff (!rst_n)
    (tick0 && $past(sel0) >= 3'd6 && sel0 == $past(sel0)) |=> !tick0); // R8
endmodule

bind tps_shared_prescaler tps_checker u_chk (
  .clk(clk), .rst_n(rst_n), .presc_clr(presc_clr),
  .sel0(sel0), .sel1(sel1), .tick0(tick0), .tick1(tick1)
);

// File: tb/sim_tps_shared_prescaler.sv
module sim_tps_shared_prescaler;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       presc_clr = 1'b0;
  logic [2:0] sel0 = 3'd2;
  logic [2:0] sel1 = 3'd0;
  logic       ext = 1'b0;
  logic       tick0, tick1;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk; // 50 MHz

  tps_shared_prescaler u0 (
    .clk(clk), .rst_n(rst_n), .presc_clr(presc_clr),
    .sel0(sel0), .sel1(sel1), .ext_pin0(ext), .ext_pin1(ext),
    .tick0(tick0), .tick1(tick1)
  );

  // {select, expected period}
  localparam int VEC [5][2] = '{'{1, 1}, '{2, 8}, '{3, 64}, '{4, 256}, '{5, 1024}};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_tick(input bit which, input int lim, output int k);
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!(which ? tick1 : tick0) && k < lim);
  endtask

  // Clear edge lies between the two negedges; returns tick0 seen right after it
  task automatic pulse_clr(output bit t0_after);
    @(negedge clk) presc_clr = 1'b1;
    @(negedge clk);
    t0_after = tick0;
    presc_clr = 1'b0;
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    int k, cnt0, cnt1, t;
    bit q;
    // R9: reset state, then first tick of /8 eight edges after release
    repeat (3) @(negedge clk);
    chk(!tick0 && !tick1, "R9 strobes low in reset", tick0, 0);
    rst_n = 1'b1;
    wait_tick(0, 50, k);
    chk(k == 8, "R9 first /8 tick after reset", k, 8);

    // R2 R3 R5: table of select values and periods
    for (int v = 0; v < 5; v++) begin
      sel0 = 3'(VEC[v][0]);
      pulse_clr(q);
      if (VEC[v][1] > 1) chk(!q, "R5 no strobe on clear edge", q, 0);
      wait_tick(0, 3000, k);
      chk(k == VEC[v][1], VEC[v][1] == 1 ? "R2 direct first" : "R5 first tick after clear",
          k, VEC[v][1]);
      for (int g = 0; g < 2; g++) begin
        wait_tick(0, 3000, k);
        chk(k == VEC[v][1], VEC[v][1] == 1 ? "R2 direct spacing" : "R3 tick spacing",
            k, VEC[v][1]);
      end
    end

    // R1: select off produces nothing
    sel0 = 3'd0;
    @(negedge clk);
    cnt0 = 0;
    for (int i = 0; i < 1100; i++) begin
      @(negedge clk);
      if (tick0) cnt0++;
    end
    chk(cnt0 == 0, "R1 no strobe when off", cnt0, 0);

    // R4: toggling the select keeps the divider phase
    sel0 = 3'd2;
    pulse_clr(q);
    t = 0;
    repeat (13) begin @(negedge clk); t++; end
    sel0 = 3'd0;
    repeat (5) begin @(negedge clk); t++; end
    sel0 = 3'd2;
    wait_tick(0, 50, k);
    t += k;
    chk(t % 8 == 0, "R4 phase kept across select change", t % 8, 0);
    chk(k >= 1 && k <= 9, "R4 first count window /8", k, 9);

    // R4: first-count window for /64 at several phases
    for (int d = 0; d < 6; d++) begin
      sel0 = 3'd0;
      repeat (d * 11 + 1) @(negedge clk);
      sel0 = 3'd3;
      wait_tick(0, 200, k);
      chk(k >= 1 && k <= 65, "R4 first count window /64", k, 65);
    end

    // R6: clearing for timer 0 realigns timer 1
    sel0 = 3'd2;
    sel1 = 3'd5;
    pulse_clr(q);
    repeat (300) @(negedge clk);
    pulse_clr(q);
    wait_tick(1, 3000, k);
    chk(k == 1024, "R6 other timer realigned by clear", k, 1024);

    // R7: independent taps at once
    sel0 = 3'd3;
    sel1 = 3'd4;
    pulse_clr(q);
    cnt0 = 0;
    cnt1 = 0;
    for (int i = 0; i < 1024; i++) begin
      @(negedge clk);
      if (tick0) cnt0++;
      if (tick1) cnt1++;
    end
    chk(cnt0 == 16, "R7 timer0 /64 count", cnt0, 16);
    chk(cnt1 == 4, "R7 timer1 /256 count", cnt1, 4);

    // R8: pin edges; timer0 rising, timer1 falling
    sel0 = 3'd7;
    sel1 = 3'd6;
    ext = 1'b0;
    repeat (6) @(negedge clk);
    ext = 1'b1;
    wait_tick(0, 20, k);
    chk(k == 3, "R8 rising edge latency", k, 3);
    chk(!tick1, "R8 falling select ignores rise", tick1, 0);
    repeat (4) @(negedge clk);
    cnt0 = 0;
    cnt1 = 0;
    for (int p = 0; p < 8; p++) begin
      ext = ~ext;
      repeat (5) begin
        @(negedge clk);
        if (tick0) cnt0++;
        if (tick1) cnt1++;
      end
    end
    chk(cnt0 == 4, "R8 rising edge count", cnt0, 4);
    chk(cnt1 == 4, "R8 falling edge count", cnt1, 4);

    finish_run();
  end
endmodule